// File: doc/BRIEF.md
# Load-Store Byte Alignment Unit

This block is the data-side lane steering stage between a 32-bit core and a little-endian data memory that is addressed by word. On a load it receives the memory word, the low bits of the byte address, the load opcode and the current value of the destination register. It produces the value to write back. That value is a byte or halfword, sign- or zero-extended, or the full word. For the two partial-word loads it is a merge of memory bytes into the old register value, so that a left/right pair assembles an unaligned word.

On a store it receives the source register value and produces the write data and per-byte write enables. The source byte or halfword is copied into every lane, and only the addressed lanes are enabled. Address generation, the memory and misalignment traps belong to neighbouring blocks. The effective address reaching the memory may come from a negative offset; only its two low bits matter here.

All results are registered once. An operation presented with `i_en` high appears on the outputs at the next rising clock edge.

Top module: `lsa_unit`

## Requirements
- R1: While reset is asserted and before the first enabled operation after it, `o_ld`, `o_wd` and `o_be` are all zero.
- R2: An operation sampled with `i_en` high appears on the outputs one clock later. In a cycle after `i_en` was low, `o_be` is zero and `o_ld` and `o_wd` keep their previous values.
- R3: Memory is little-endian: byte offset k (address bits 1:0) is bits 8k+7:8k of the word. Opcode 100000 returns that byte sign-extended. Opcode 100100 returns it zero-extended, so 0x8A gives 0xFFFFFF8A and 0x0000008A respectively.
- R4: Opcode 100001 returns the halfword in bits 31:16 when address bit 1 is set and bits 15:0 otherwise, sign-extended; address bit 0 is ignored. Opcode 100101 does the same with zero extension (0x8123 gives 0xFFFF8123 and 0x00008123).
- R5: Opcode 100011 returns the memory word unchanged for every offset.
- R6: Opcode 100010 (left partial load) at offset k places memory bytes k..0 into register bytes 3..3-k and keeps the lower 3-k bytes of the old value: result = (mem << 8(3-k)) | (old & (2^(8(3-k)) - 1)).
- R7: Opcode 100110 (right partial load) at offset k places memory bytes 3..k into register bytes 3-k..0 and keeps the upper k bytes of the old value: result = (mem >> 8k) | (old & ~(0xFFFFFFFF >> 8k)).
- R8: Opcode 101000 (byte store) drives source bits 7:0 into all four lanes of `o_wd` and sets only enable bit k.
- R9: Opcode 101001 (halfword store) drives source bits 15:0 into both halves of `o_wd`. It sets enables 3:2 when address bit 1 is set and enables 1:0 otherwise.
- R10: Opcode 101011 (word store) drives the source unchanged with all four enables set, for every offset.
- R11: Any opcode that is not a store gives `o_be` = 0 and `o_wd` = 0. Any opcode that is not a load gives `o_ld` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| i_en | input | 1 | Operation valid in this cycle |
| i_op | input | 6 | Load/store opcode |
| i_ofs | input | 2 | Byte address bits 1:0 |
| i_mem | input | 32 | Word read from data memory |
| i_old | input | 32 | Current destination register value |
| i_src | input | 32 | Store source register value |
| o_ld | output | 32 | Aligned load result |
| o_wd | output | 32 | Lane-replicated store data |
| o_be | output | 4 | Per-byte write enables |

## Verification
A wrong lane selection shows at the ports one cycle after the enabled operation. It appears either as a wrong byte in `o_ld` or `o_wd`, or as an enable pattern with the wrong count or position. A merge error in the partial-word loads shows only for offsets where old bytes are kept, so all four offsets are swept with old values that differ from memory. A stuck enable register would write memory on idle cycles, and this shows on the first cycle after `i_en` falls.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [5:0] {
    OP_LDB  = 6'b100000,
    OP_LDBU = 6'b100100,
    OP_LDH  = 6'b100001,
    OP_LDHU = 6'b100101,
    OP_LDW  = 6'b100011,
    OP_LDL  = 6'b100010,
    OP_LDR  = 6'b100110,
    OP_STB  = 6'b101000,
    OP_STH  = 6'b101001,
    OP_STW  = 6'b101011
  } lsa_op_e;

  function automatic logic is_store(input logic [5:0] op);
    return (op == OP_STB) || (op == OP_STH) || (op == OP_STW);
  endfunction

  function automatic logic is_load(input logic [5:0] op);
    return (op == OP_LDB) || (op == OP_LDBU) || (op == OP_LDH) ||
           (op == OP_LDHU) || (op == OP_LDW) || (op == OP_LDL) ||
           (op == OP_LDR);
  endfunction
endpackage

// File: rtl/lsa_rst_sync.sv
module lsa_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/lsa_load_align.sv
module lsa_load_align
  import lsa_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = $clog2(DW / 8)
) (
  input  logic [5:0]       op,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    mem,
  input  logic [DW-1:0]    old,
  output logic [DW-1:0]    ld
);
  localparam int LANES = DW / 8;

  logic [7:0]  byte_sel;
  logic [15:0] half_sel;
  int          k;
  int          shift;

  always_comb begin
    k        = int'(ofs);
    byte_sel = mem[8*k +: 8];
    half_sel = mem[16*(k/2) +: 16];
    shift    = LANES - 1 - k;
    ld       = '0;
    case (op)
      OP_LDB:  ld = {{(DW-8){byte_sel[7]}}, byte_sel};
      OP_LDBU: ld = {{(DW-8){1'b0}}, byte_sel};
      OP_LDH:  ld = {{(DW-16){half_sel[15]}}, half_sel};
      OP_LDHU: ld = {{(DW-16){1'b0}}, half_sel};
      OP_LDW:  ld = mem;
      OP_LDL: begin
        for (int j = 0; j < LANES; j++) begin
          if (j >= shift) ld[8*j +: 8] = mem[8*(j-shift) +: 8];
          else            ld[8*j +: 8] = old[8*j +: 8];
        end
      end
      OP_LDR: begin
        for (int j = 0; j < LANES; j++) begin
          if (j <= shift) ld[8*j +: 8] = mem[8*(j+k) +: 8];
          else            ld[8*j +: 8] = old[8*j +: 8];
        end
      end
      default: ld = '0;
    endcase
  end
endmodule

// File: rtl/lsa_store_align.sv
module lsa_store_align
  import lsa_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = $clog2(DW / 8)
) (
  input  logic [5:0]        op,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DW-1:0]     src,
  output logic [DW-1:0]     wd,
  output logic [DW/8-1:0]   be
);
  localparam int LANES = DW / 8;

  logic [DW-1:0]    rep_b;
  logic [DW-1:0]    rep_h;
  logic [LANES-1:0] be_b;
  logic [LANES-1:0] be_h;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rep_b[8*g +: 8] = src[7:0];
    assign rep_h[8*g +: 8] = src[8*(g%2) +: 8];
    assign be_b[g]         = (ofs == OFS_W'(g));
    assign be_h[g]         = (ofs[OFS_W-1:1] == (OFS_W-1)'(g/2));
  end

  always_comb begin
    wd = '0;
    be = '0;
    case (op)
      OP_STB: begin wd = rep_b; be = be_b; end
      OP_STH: begin wd = rep_h; be = be_h; end
      OP_STW: begin wd = src;   be = '1;   end
      default: begin wd = '0;   be = '0;   end
    endcase
  end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int DW    = 32,
  parameter int OFS_W = $clog2(DW / 8)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             i_en,
  input  logic [5:0]       i_op,
  input  logic [OFS_W-1:0] i_ofs,
  input  logic [DW-1:0]    i_mem,
  input  logic [DW-1:0]    i_old,
  input  logic [DW-1:0]    i_src,
  output logic [DW-1:0]    o_ld,
  output logic [DW-1:0]    o_wd,
  output logic [DW/8-1:0]  o_be
);
  localparam int LANES = DW / 8;

  logic             srst_n;
  logic [DW-1:0]    ld_c, wd_c;
  logic [LANES-1:0] be_c;
  logic [DW-1:0]    ld_d, ld_q, wd_d, wd_q;
  logic [LANES-1:0] be_d, be_q;

  lsa_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  lsa_load_align #(.DW(DW), .OFS_W(OFS_W)) i_load (
    .op(i_op), .ofs(i_ofs), .mem(i_mem), .old(i_old), .ld(ld_c)
  );

  lsa_store_align #(.DW(DW), .OFS_W(OFS_W)) i_store (
    .op(i_op), .ofs(i_ofs), .src(i_src), .wd(wd_c), .be(be_c)
  );

  always_comb begin
    ld_d = i_en ? ld_c : ld_q;
    wd_d = i_en ? wd_c : wd_q;
    be_d = i_en ? be_c : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ld_q <= '0;
      wd_q <= '0;
      be_q <= '0;
    end else begin
      ld_q <= ld_d;
      wd_q <= wd_d;
      be_q <= be_d;
    end
  end

  assign o_ld = ld_q;
  assign o_wd = wd_q;
  assign o_be = be_q;

  p_idle_no_write_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !i_en |=> (o_be == '0));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !i_en |=> ($stable(o_ld) && $stable(o_wd)));
  p_byte_sext_r3: assert property (@(posedge clk) disable iff (!srst_n)
    (i_en && i_op == OP_LDB) |=> (o_ld[DW-1:8] == {(DW-8){o_ld[7]}}));
  p_word_load_r5: assert property (@(posedge clk) disable iff (!srst_n)
    (i_en && i_op == OP_LDW) |=> (o_ld == $past(i_mem)));
  p_byte_one_lane_r8: assert property (@(posedge clk) disable iff (!srst_n)
    (i_en && i_op == OP_STB) |=> ($countones(o_be) == 1));
  p_half_two_lanes_r9: assert property (@(posedge clk) disable iff (!srst_n)
    (i_en && i_op == OP_STH) |=> ($countones(o_be) == 2 && o_be[0] == o_be[1]));
  p_word_all_lanes_r10: assert property (@(posedge clk) disable iff (!srst_n)
    (i_en && i_op == OP_STW) |=> (o_be == '1));
  p_load_no_write_r11: assert property (@(posedge clk) disable iff (!srst_n)
    (i_en && !is_store(i_op)) |=> (o_be == '0 && o_wd == '0));
endmodule

// File: tb/test_lsa_unit.sv
module test_lsa_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        i_en = 1'b0;
  logic [5:0]  i_op = '0;
  logic [1:0]  i_ofs = '0;
  logic [31:0] i_mem = '0, i_old = '0, i_src = '0;
  logic [31:0] o_ld, o_wd;
  logic [3:0]  o_be;

  int errors = 0;
  int checks = 0;
  logic [31:0] lcg = 32'h1234_abcd;

  always #10 clk = ~clk;

  lsa_unit i_lsa_unit (
    .clk(clk), .rst_n(rst_n), .i_en(i_en), .i_op(i_op), .i_ofs(i_ofs),
    .i_mem(i_mem), .i_old(i_old), .i_src(i_src),
    .o_ld(o_ld), .o_wd(o_wd), .o_be(o_be)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [5:0] op);
    case (op)
      6'b100000, 6'b100100: return "R3";
      6'b100001, 6'b100101: return "R4";
      6'b100011: return "R5";
      6'b100010: return "R6";
      6'b100110: return "R7";
      6'b101000: return "R8";
      6'b101001: return "R9";
      6'b101011: return "R10";
      default:   return "R11";
    endcase
  endfunction

  task automatic model(input logic [5:0] op, input int k,
                       input logic [31:0] mem, old, src,
                       output logic [31:0] ld, wd, output logic [3:0] be);
    logic [63:0] lmask;
    logic [31:0] b, h;
    b  = (mem >> (8*k)) & 32'hFF;
    h  = (mem >> (16*(k/2))) & 32'hFFFF;
    ld = 0; wd = 0; be = 0;
    case (op)
      6'b100000: ld = (b >= 32'h80) ? (b | 32'hFFFFFF00) : b;
      6'b100100: ld = b;
      6'b100001: ld = (h >= 32'h8000) ? (h | 32'hFFFF0000) : h;
      6'b100101: ld = h;
      6'b100011: ld = mem;
      6'b100010: begin
        lmask = (64'd1 << (8*(3-k))) - 64'd1;
        ld = (mem << (8*(3-k))) | (old & lmask[31:0]);
      end
      6'b100110: ld = (mem >> (8*k)) | (old & ~(32'hFFFFFFFF >> (8*k)));
      6'b101000: begin wd = (src & 32'hFF) * 32'h01010101; be = 4'(1 << k); end
      6'b101001: begin wd = (src & 32'hFFFF) * 32'h00010001; be = (k >= 2) ? 4'hC : 4'h3; end
      6'b101011: begin wd = src; be = 4'hF; end
      default: ;
    endcase
  endtask

  task automatic run_op(input logic [5:0] op, input int k,
                        input logic [31:0] mem, old, src);
    logic [31:0] eld, ewd;
    logic [3:0]  ebe;
    string t;
    model(op, k, mem, old, src, eld, ewd, ebe);
    t = tag_of(op);
    i_en = 1'b1; i_op = op; i_ofs = 2'(k); i_mem = mem; i_old = old; i_src = src;
    @(negedge clk);
    chk(o_ld == eld, t, "load result", o_ld, eld);
    chk(o_wd == ewd, t, "store data", o_wd, ewd);
    chk(o_be == ebe, t, "byte enables", {28'd0, o_be}, {28'd0, ebe});
  endtask

  task automatic idle_check;
    logic [31:0] pld, pwd;
    pld = o_ld; pwd = o_wd;
    i_en = 1'b0; i_op = 6'b101011; i_src = ~i_src; i_mem = ~i_mem;
    @(negedge clk);
    chk(o_be == 4'h0, "R2", "idle enables", {28'd0, o_be}, 32'd0);
    chk(o_ld == pld && o_wd == pwd, "R2", "idle hold", o_ld ^ o_wd, pld ^ pwd);
  endtask

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    return x * 32'd1664525 + 32'd1013904223;
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=%0d expected=%0d", 5000, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [5:0] ops [14];
    logic [31:0] pats [4];
    ops = '{6'b100000, 6'b100100, 6'b100001, 6'b100101, 6'b100011,
            6'b100010, 6'b100110, 6'b101000, 6'b101001, 6'b101011,
            6'b000000, 6'b100111, 6'b101010, 6'b111111};
    pats = '{32'h0000008A, 32'h00008123, 32'hFFFFFFFF, 32'h00000000};
    @(negedge clk);
    // R1: outputs cleared during reset
    chk(o_ld == 0 && o_wd == 0, "R1", "reset data", o_ld | o_wd, 32'd0);
    chk(o_be == 0, "R1", "reset enables", {28'd0, o_be}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(o_ld == 0 && o_wd == 0 && o_be == 0, "R1", "after release",
        o_ld | o_wd | {28'd0, o_be}, 32'd0);
    // Directed: lane placement with known patterns
    run_op(6'b100000, 2, 32'h008A0000, 32'h0, 32'h0);
    run_op(6'b100100, 2, 32'h008A0000, 32'h0, 32'h0);
    run_op(6'b100001, 0, 32'h00008123, 32'h0, 32'h0);
    run_op(6'b100001, 1, 32'h00008123, 32'h0, 32'h0);
    run_op(6'b101001, 0, 32'h0, 32'h0, 32'h00005678);
    idle_check();
    // Sweep: every opcode, every offset, several data patterns
    for (int p = 0; p < 10; p++) begin
      for (int o = 0; o < 14; o++) begin
        for (int k = 0; k < 4; k++) begin
          logic [31:0] m, ol, s;
          if (p < 4) begin
            m = pats[p]; ol = ~pats[p]; s = pats[(p+1)%4];
          end else begin
            lcg = next_rand(lcg); m = lcg;
            lcg = next_rand(lcg); ol = lcg;
            lcg = next_rand(lcg); s = lcg;
          end
          run_op(ops[o], k, m, ol, s);
          if ((o + k) % 5 == 0) idle_check();
        end
      end
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule